// File: doc/BRIEF.md
# Triadic RISC Execute Core with Delayed Branches

This block is a compact in-order core. It fetches one fixed-width 32-bit instruction per cycle from a local instruction memory port and executes it in the same cycle. The opcode sits in the top byte. The three lower bytes hold a destination register, a first source register, and either a second source register or an 8-bit immediate. The core covers register/immediate and register/register arithmetic and logic, constant shifts and rotates, and immediate loads that update only part of a register. It also covers relative conditional branches, absolute jumps and jumps through a register.

Control transfers are delayed by one instruction. The instruction that follows a taken branch or jump always executes, and the fetch then continues at the target. A debug read port exposes any register of the file combinationally. A halt input freezes the core in place.

Top module: `tri_core`

## Requirements
- R1: While reset (`rstN` low) is applied and after its release, the fetch address is 0 and every register reads 0.
- R2: Opcodes 0x00..0x07 write `dst` (bits 23:16) from `src` (bits 15:8) and the zero-extended immediate (bits 7:0). The operations are, in opcode order: src+imm, src-imm, src AND NOT imm, imm-src, AND, OR, NOR, XOR. A register field naming an index at or above the register count reads as zero and writes nowhere.
- R3: Opcodes 0x10..0x17 perform the same eight operations as R2, with register A in bits 15:8 and register B in bits 7:0 in place of the immediate. Opcode 0x11 yields A-B and opcode 0x13 yields B-A.
- R4: Opcode 0x40 yields {8'h00, imm, src[15:0]}. Opcode 0x4B yields {16'h0000, imm, src[7:0]}.
- R5: Opcodes 0x44, 0x45, 0x46 and 0x47 apply rotate-right, shift-left, arithmetic shift-right and logical shift-right to src. The amount is the low 5 bits of the immediate.
- R6: Opcodes 0x60..0x65 branch when the register in bits 7:0 is zero, nonzero, negative, non-negative, signed greater than zero, or signed less than or equal to zero, in that order. The target is pc+4 plus 4 times the signed 16-bit displacement in bits 23:8, so a displacement of -1 targets the branch itself.
- R7: The instruction after a taken branch or jump always executes, and the instruction after that one is fetched from the target. An untaken branch continues sequentially.
- R8: Opcode 0x6C jumps to bits 23:0 shifted left by 2. Opcode 0x6F jumps to the value of the register named in bits 7:0, with its low two bits cleared.
- R9: A branch or jump that sits in a delay slot has no effect on control flow.
- R10: Any opcode not listed in R2 to R8 changes neither the registers nor the sequential flow.
- R11: While `halt` is high, the fetch address and every register hold their values.
- R12: `dbgData` shows the register selected by `dbgSel` in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| halt | input | 1 | Freezes fetch and register writes |
| imemAddr | output | PC_W | Byte address of the instruction being executed |
| imemData | input | 32 | Instruction word at imemAddr, same cycle |
| dbgSel | input | $clog2(NUM_REGS) | Register index for the debug port |
| dbgData | output | 32 | Contents of the selected register |

## Verification
A decode fault in this core lands in the register file one clock edge after the faulty instruction executes. It then shows on the debug port as a wrong value, and the tests read that value after their program reaches a closed loop. Delay-slot or target faults show up as registers that were set when they should have been skipped, or skipped when they should have been set. They also show up as a fetch address that never settles into the expected terminating loop. A halt fault shows as a fetch address or register that changes during a halted window.

// File: rtl/tri_core_pkg.sv
package tri_core_pkg;

  typedef enum logic [3:0] {
    ALU_ADD  = 4'd0,
    ALU_SUB  = 4'd1,
    ALU_ANDN = 4'd2,
    ALU_RSUB = 4'd3,
    ALU_AND  = 4'd4,
    ALU_OR   = 4'd5,
    ALU_NOR  = 4'd6,
    ALU_XOR  = 4'd7,
    ALU_HI16 = 4'd8,
    ALU_MID8 = 4'd9,
    ALU_ROR  = 4'd10,
    ALU_SHL  = 4'd11,
    ALU_SAR  = 4'd12,
    ALU_SHR  = 4'd13
  } aluOp_e;

  // Strobes from control to datapath for the instruction in execution
  typedef struct packed {
    logic       wrEn;
    logic       useImm;
    aluOp_e     aluOp;
    logic [7:0] dstSel;
    logic [7:0] srcASel;
    logic [7:0] srcBSel;
    logic [7:0] imm;
  } dpStrobe_t;

  localparam logic [7:0] OP_LDHI16 = 8'h40;
  localparam logic [7:0] OP_ROR    = 8'h44;
  localparam logic [7:0] OP_SHL    = 8'h45;
  localparam logic [7:0] OP_SAR    = 8'h46;
  localparam logic [7:0] OP_SHR    = 8'h47;
  localparam logic [7:0] OP_LDMID8 = 8'h4B;
  localparam logic [7:0] OP_BR_LO  = 8'h60;
  localparam logic [7:0] OP_BR_HI  = 8'h65;
  localparam logic [7:0] OP_JABS   = 8'h6C;
  localparam logic [7:0] OP_JREG   = 8'h6F;

endpackage

// File: rtl/tri_alu.sv
module tri_alu
  import tri_core_pkg::*;
(
  input  aluOp_e      op,
  input  logic [31:0] a,
  input  logic [31:0] b,
  output logic [31:0] y
);

  logic [4:0] shAmt;
  assign shAmt = b[4:0];

  always_comb begin
    unique case (op)
      ALU_ADD:  y = a + b;
      ALU_SUB:  y = a - b;
      ALU_ANDN: y = a & ~b;
      ALU_RSUB: y = b - a;
      ALU_AND:  y = a & b;
      ALU_OR:   y = a | b;
      ALU_NOR:  y = ~(a | b);
      ALU_XOR:  y = a ^ b;
      ALU_HI16: y = {8'h00, b[7:0], a[15:0]};
      ALU_MID8: y = {16'h0000, b[7:0], a[7:0]};
      ALU_ROR:  y = 32'({a, a} >> shAmt);
      ALU_SHL:  y = a << shAmt;
      ALU_SAR:  y = 32'($signed(a) >>> shAmt);
      ALU_SHR:  y = a >> shAmt;
      default:  y = a;
    endcase
  end

endmodule

// File: rtl/tri_dpath.sv
module tri_dpath
  import tri_core_pkg::*;
#(
  parameter int NUM_REGS = 16,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             halt,
  input  dpStrobe_t        strb,
  input  logic [IDX_W-1:0] dbgSel,
  output logic [31:0]      dbgData,
  output logic [31:0]      srcBVal
);

  logic [NUM_REGS-1:0][31:0] regQ;
  logic [31:0] srcAVal, opB, aluRes;

  function automatic logic [31:0] readReg(input logic [NUM_REGS-1:0][31:0] rf,
                                          input logic [7:0] sel);
    logic [31:0] v;
    v = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (sel == 8'(i)) v = rf[i];
    return v;
  endfunction

  assign srcAVal = readReg(regQ, strb.srcASel);
  assign srcBVal = readReg(regQ, strb.srcBSel);
  assign opB     = strb.useImm ? {24'h0, strb.imm} : srcBVal;
  assign dbgData = regQ[dbgSel];

  tri_alu uAlu (
    .op (strb.aluOp),
    .a  (srcAVal),
    .b  (opB),
    .y  (aluRes)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regQ <= '0;
    end else if (!halt && strb.wrEn) begin
      for (int i = 0; i < NUM_REGS; i++)
        if (strb.dstSel == 8'(i)) regQ[i] <= aluRes;
    end
  end

  AST_HALT_HOLDS_REGS: assert property (@(posedge clk) disable iff (!rstN)
    halt |=> $stable(regQ)); // R11

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    (!halt && strb.wrEn && strb.dstSel < 8'(NUM_REGS))
      |=> regQ[$past(strb.dstSel[IDX_W-1:0])] == $past(aluRes)); // R2

  AST_NO_WRITE_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrEn |=> $stable(regQ)); // R10

endmodule

// File: rtl/tri_ctrl.sv
module tri_ctrl
  import tri_core_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            halt,
  input  logic [31:0]     instr,
  input  logic [31:0]     srcBVal,
  output logic [PC_W-1:0] pcOut,
  output dpStrobe_t       strb
);

  logic [PC_W-1:0] pcQ, tgtQ, seqPc, brTgt, absTgt, regTgt, redirTgt;
  logic            slotQ;
  logic [7:0]      op;
  logic [31:0]     dispBytes;
  logic [31:0]     absBytes;
  logic            isCond, condMet, redirReq, valZero, valNeg;

  assign op        = instr[31:24];
  assign valZero   = (srcBVal == 32'h0);
  assign valNeg    = srcBVal[31];
  assign dispBytes = {{14{instr[23]}}, instr[23:8], 2'b00};
  assign absBytes  = {6'h00, instr[23:0], 2'b00};
  assign seqPc     = pcQ + PC_W'(4);
  assign brTgt     = seqPc + dispBytes[PC_W-1:0];
  assign absTgt    = absBytes[PC_W-1:0];
  assign regTgt    = {srcBVal[PC_W-1:2], 2'b00};
  assign pcOut     = pcQ;

  // Field decode into datapath strobes
  always_comb begin
    strb.wrEn    = 1'b0;
    strb.useImm  = 1'b1;
    strb.aluOp   = ALU_ADD;
    strb.dstSel  = instr[23:16];
    strb.srcASel = instr[15:8];
    strb.srcBSel = instr[7:0];
    strb.imm     = instr[7:0];
    if (op[7:3] == 5'b00000) begin
      strb.wrEn  = 1'b1;
      strb.aluOp = aluOp_e'({1'b0, op[2:0]});
    end else if (op[7:3] == 5'b00010) begin
      strb.wrEn   = 1'b1;
      strb.useImm = 1'b0;
      strb.aluOp  = aluOp_e'({1'b0, op[2:0]});
    end else begin
      unique case (op)
        OP_LDHI16: begin strb.wrEn = 1'b1; strb.aluOp = ALU_HI16; end
        OP_LDMID8: begin strb.wrEn = 1'b1; strb.aluOp = ALU_MID8; end
        OP_ROR:    begin strb.wrEn = 1'b1; strb.aluOp = ALU_ROR;  end
        OP_SHL:    begin strb.wrEn = 1'b1; strb.aluOp = ALU_SHL;  end
        OP_SAR:    begin strb.wrEn = 1'b1; strb.aluOp = ALU_SAR;  end
        OP_SHR:    begin strb.wrEn = 1'b1; strb.aluOp = ALU_SHR;  end
        default:   ;
      endcase
    end
  end

  // Branch condition and redirect selection
  always_comb begin
    isCond = (op >= OP_BR_LO) && (op <= OP_BR_HI);
    unique case (op[2:0])
      3'd0:    condMet = valZero;
      3'd1:    condMet = !valZero;
      3'd2:    condMet = valNeg;
      3'd3:    condMet = !valNeg;
      3'd4:    condMet = !valNeg && !valZero;
      default: condMet = valNeg || valZero;
    endcase
    redirReq = (isCond && condMet) || (op == OP_JABS) || (op == OP_JREG);
    if (op == OP_JABS)      redirTgt = absTgt;
    else if (op == OP_JREG) redirTgt = regTgt;
    else                    redirTgt = brTgt;
  end

  // The slot flag gives the pending target priority, so a control
  // transfer decoded inside a delay slot is dropped.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ   <= '0;
      tgtQ  <= '0;
      slotQ <= 1'b0;
    end else if (!halt) begin
      if (slotQ) begin
        pcQ   <= tgtQ;
        slotQ <= 1'b0;
      end else if (redirReq) begin
        pcQ   <= seqPc;
        tgtQ  <= redirTgt;
        slotQ <= 1'b1;
      end else begin
        pcQ   <= seqPc;
      end
    end
  end

  AST_HALT_HOLDS_PC: assert property (@(posedge clk) disable iff (!rstN)
    halt |=> $stable(pcQ)); // R11

  AST_SLOT_IS_SEQUENTIAL: assert property (@(posedge clk) disable iff (!rstN)
    (!halt && !slotQ && redirReq) |=> (pcQ == $past(pcQ) + PC_W'(4))); // R7

  AST_SLOT_THEN_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    (!halt && slotQ) |=> (pcQ == $past(tgtQ) && !slotQ)); // R9

  AST_PC_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (imemAlignedOk(pcQ))); // R8

  function automatic logic imemAlignedOk(input logic [PC_W-1:0] p);
    return p[1:0] == 2'b00;
  endfunction

endmodule

// File: rtl/tri_core.sv
module tri_core
  import tri_core_pkg::*;
#(
  parameter int PC_W     = 16,
  parameter int NUM_REGS = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        halt,
  output logic [PC_W-1:0]             imemAddr,
  input  logic [31:0]                 imemData,
  input  logic [$clog2(NUM_REGS)-1:0] dbgSel,
  output logic [31:0]                 dbgData
);

  dpStrobe_t   strb;
  logic [31:0] srcBVal;

  tri_ctrl #(.PC_W(PC_W)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .halt    (halt),
    .instr   (imemData),
    .srcBVal (srcBVal),
    .pcOut   (imemAddr),
    .strb    (strb)
  );

  tri_dpath #(.NUM_REGS(NUM_REGS)) uDpath (
    .clk     (clk),
    .rstN    (rstN),
    .halt    (halt),
    .strb    (strb),
    .dbgSel  (dbgSel),
    .dbgData (dbgData),
    .srcBVal (srcBVal)
  );

endmodule

// File: tb/tb_tri_core.sv
module tb_tri_core;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] NOP = 32'hFF00_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        halt = 1'b0;
  logic [15:0] imemAddr;
  logic [31:0] imemData;
  logic [3:0]  dbgSel = '0;
  logic [31:0] dbgData;
  logic [31:0] imem [64];
  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign imemData = imem[imemAddr[7:2]];

  tri_core dut (
    .clk(clk), .rstN(rstN), .halt(halt), .imemAddr(imemAddr),
    .imemData(imemData), .dbgSel(dbgSel), .dbgData(dbgData)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic regIs(input string tag, input int idx, input logic [31:0] exp);
    dbgSel = 4'(idx);
    #1;
    check(tag, dbgData, exp);
  endtask

  task automatic clearMem();
    for (int i = 0; i < 64; i++) imem[i] = NOP;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic runCycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic testImmOps();
    clearMem();
    imem[0] = 32'h0001_00F0; imem[1] = 32'h0102_0110; imem[2] = 32'h0203_0130;
    imem[3] = 32'h0304_0105; imem[4] = 32'h0405_013C; imem[5] = 32'h0506_010F;
    imem[6] = 32'h0607_010F; imem[7] = 32'h0708_01FF; imem[8] = 32'h6C00_0008;
    doReset(); runCycles(30);
    regIs("R2 addi", 1, 32'h0000_00F0);
    regIs("R2 subi", 2, 32'h0000_00E0);
    regIs("R2 andni", 3, 32'h0000_00C0);
    regIs("R2 rsubi", 4, 32'hFFFF_FF15);
    regIs("R2 andi", 5, 32'h0000_0030);
    regIs("R2 ori", 6, 32'h0000_00FF);
    regIs("R2 nori", 7, 32'hFFFF_FF00);
    regIs("R2 xori", 8, 32'h0000_000F);
  endtask

  task automatic testRegOps();
    clearMem();
    imem[0] = 32'h0001_0030; imem[1] = 32'h0002_0005;
    imem[2] = 32'h1003_0102; imem[3] = 32'h1104_0102; imem[4] = 32'h1305_0102;
    imem[5] = 32'h1206_0102; imem[6] = 32'h1407_0102; imem[7] = 32'h1508_0102;
    imem[8] = 32'h1609_0102; imem[9] = 32'h170A_0102; imem[10] = 32'h6C00_000A;
    doReset(); runCycles(30);
    regIs("R3 add", 3, 32'h0000_0035);
    regIs("R3 sub A-B", 4, 32'h0000_002B);
    regIs("R3 rsub B-A", 5, 32'hFFFF_FFD5);
    regIs("R3 andn", 6, 32'h0000_0030);
    regIs("R3 and", 7, 32'h0000_0000);
    regIs("R3 or", 8, 32'h0000_0035);
    regIs("R3 nor", 9, 32'hFFFF_FFCA);
    regIs("R3 xor", 10, 32'h0000_0035);
  endtask

  task automatic testPartial();
    clearMem();
    imem[0] = 32'h0001_00AB; imem[1] = 32'h4001_01CD; imem[2] = 32'h4B02_01EF;
    imem[3] = 32'h4003_0112; imem[4] = 32'h6C00_0004;
    doReset(); runCycles(20);
    regIs("R4 hi16", 1, 32'h00CD_00AB);
    regIs("R4 mid8", 2, 32'h0000_EFAB);
    regIs("R4 hi16 again", 3, 32'h0012_00AB);
  endtask

  task automatic testShifts();
    clearMem();
    imem[0] = 32'h0601_007E; imem[1] = 32'h4402_0104; imem[2] = 32'h4503_0124;
    imem[3] = 32'h4604_0104; imem[4] = 32'h4705_0104; imem[5] = 32'h4406_0100;
    imem[6] = 32'h6C00_0006;
    doReset(); runCycles(20);
    regIs("R5 ror", 2, 32'h1FFF_FFF8);
    regIs("R5 shl low5", 3, 32'hFFFF_F810);
    regIs("R5 sar", 4, 32'hFFFF_FFF8);
    regIs("R5 shr", 5, 32'h0FFF_FFF8);
    regIs("R5 ror0", 6, 32'hFFFF_FF81);
  endtask

  task automatic testBranches();
    clearMem();
    imem[0] = 32'h0001_0005; imem[1] = 32'h0602_0000; imem[2] = 32'h6000_0200;
    imem[3] = 32'h0003_0011; imem[4] = 32'h0004_0022; imem[5] = 32'h6100_0200;
    imem[6] = 32'h0005_0033; imem[7] = 32'h6200_0202; imem[9] = 32'h000A_0077;
    imem[10] = 32'h6300_0502; imem[11] = 32'h0006_0044; imem[12] = 32'h6400_0201;
    imem[14] = 32'h000B_0088; imem[15] = 32'h6500_0301; imem[16] = 32'h6500_0200;
    imem[17] = 32'h0007_0055; imem[18] = 32'h000C_0099; imem[19] = 32'h6400_0402;
    imem[20] = 32'h0008_0066; imem[21] = 32'h60FF_FF00;
    doReset(); runCycles(60);
    regIs("R7 slot after jz", 3, 32'h0000_0011);
    regIs("R6 jz skip", 4, 32'h0);
    regIs("R6 jnz untaken", 5, 32'h0000_0033);
    regIs("R6 js skip", 10, 32'h0);
    regIs("R6 jns untaken", 6, 32'h0000_0044);
    regIs("R6 ja skip", 11, 32'h0);
    regIs("R7 slot after jna", 7, 32'h0000_0055);
    regIs("R6 jna skip", 12, 32'h0);
    regIs("R6 ja untaken neg", 8, 32'h0000_0066);
    checks++;
    if (imemAddr != 16'h54 && imemAddr != 16'h58) begin
      fails++;
      $display("FAIL R6 self-branch loop: got %04h expected 0054/0058", imemAddr);
    end
  endtask

  task automatic testJumps();
    clearMem();
    imem[0] = 32'h0001_0040; imem[1] = 32'h6C00_0008; imem[2] = 32'h0002_0001;
    imem[3] = 32'h0003_0001; imem[8] = 32'h6F00_0001; imem[9] = 32'h6C00_0014;
    imem[10] = 32'h0004_0001; imem[16] = 32'h0005_0007; imem[17] = 32'h6C00_0011;
    imem[20] = 32'h0006_0001;
    doReset(); runCycles(30);
    regIs("R7 jmp slot runs", 2, 32'h1);
    regIs("R8 abs skip", 3, 32'h0);
    regIs("R8 reg jump skip", 4, 32'h0);
    regIs("R8 reg target reached", 5, 32'h7);
    regIs("R9 slot jump ignored", 6, 32'h0);
  endtask

  task automatic testUndefined();
    clearMem();
    imem[0] = 32'h0001_0009; imem[1] = 32'h2001_0005; imem[2] = 32'h4101_0100;
    imem[3] = 32'h6D00_0000; imem[4] = 32'h0002_0101; imem[5] = 32'h6C00_0005;
    doReset(); runCycles(20);
    regIs("R10 undefined no write", 1, 32'h9);
    regIs("R10 flow continues", 2, 32'hA);
  endtask

  task automatic testHalt();
    clearMem();
    imem[0] = 32'h0001_0101; imem[1] = 32'h6C00_0000; imem[2] = 32'h0002_0201;
    halt = 1'b1;
    doReset(); runCycles(10);
    check("R1 pc after reset", 32'(imemAddr), 32'h0);
    for (int i = 0; i < 16; i++) regIs("R1 reg cleared", i, 32'h0);
    @(negedge clk); halt = 1'b0;
    repeat (6) @(posedge clk);
    @(negedge clk); halt = 1'b1;
    regIs("R11 run r1", 1, 32'h2);
    regIs("R11 run r2", 2, 32'h2);
    check("R11 run pc", 32'(imemAddr), 32'h0);
    runCycles(10);
    check("R11 halted pc", 32'(imemAddr), 32'h0);
    regIs("R11 halted r1", 1, 32'h2);
    regIs("R12 debug select r2", 2, 32'h2);
    regIs("R12 debug select r0", 0, 32'h0);
    halt = 1'b0;
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    testImmOps();
    testRegOps();
    testPartial();
    testShifts();
    testBranches();
    testJumps();
    testUndefined();
    testHalt();
    finishRun();
  end

endmodule